// File: doc/BRIEF.md
# Display Identification Serial Streamer

This block holds a small identification memory for a display and sends its contents out serially. A dedicated slow clock, VCLK, drives the stream while the block is in transmit-only mode, which is the mode it powers up in. On entry to that mode the data line stays released for a fixed number of VCLK pulses. After that, every VCLK rising edge launches one bit. Each byte goes out most-significant bit first and is followed by a high spacer bit. The first byte sent is the one at the top address. The stream then continues from address zero upward and wraps around for as long as VCLK runs.

A mode controller sits beside the streamer. A falling edge on the two-wire clock SCL moves the block into bidirectional two-wire mode, where the streamer is silent. A long high pulse followed by a long low stretch on MODE returns the block to transmit-only mode and re-arms the stream. The two-wire protocol engine lives outside this block. The SDA line is open drain: the block pulls it low only to send a 0. A parallel load port fills the memory. It follows valid/ready rules with ready held high, so a write is accepted in every cycle where valid is high, and it never applies back-pressure.

Top module: `ddc_id_streamer`

## Requirements
- R1: While reset is low and directly after it, tx_only is 1, sda_oe is 0 and sda_out is 1.
- R2: After each entry to transmit-only mode, the first 9 VCLK rising edges leave the line released (sda_oe 0).
- R3: From the 10th VCLK rising edge on, each VCLK rising edge launches one bit. Data bits of a byte go out from bit 7 down to bit 0. Outputs change only in response to a VCLK rising edge or a mode change, within three system clock edges of the VCLK transition.
- R4: After bit 0 of each byte, one spacer bit of value 1 is sent, so each byte takes 9 VCLK pulses.
- R5: The first byte after entry comes from address 127. It is followed by bytes from addresses 0, 1, 2 and upward, and address 127 wraps to 0.
- R6: The line is pulled low (sda_oe 1) only in transmit-only mode and only for a data bit of 0. sda_out carries the bit value and reads 1 whenever the line is released.
- R7: In transmit-only mode, a falling edge on SCL sets tx_only to 0 and releases the line. A rising edge on SCL has no effect.
- R8: In two-wire mode, VCLK pulses and SCL edges have no effect: the line stays released and tx_only stays 0.
- R9: In two-wire mode, MODE sampled high for at least MIN_PULSE system clocks and then sampled low for at least MIN_PULSE system clocks sets tx_only to 1. A shorter high phase or a shorter low phase does not.
- R10: Each re-entry to transmit-only mode re-arms the 9 released pulses and the start address 127.
- R11: load_ready is always 1. A beat with load_valid high writes load_data to load_addr at that clock edge, and later stream bits from that address reflect the new value.
- R12: In transmit-only mode, MODE pulses have no effect on tx_only or on the stream position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, stands for power-on |
| vclk_in | input | 1 | Asynchronous stream clock for transmit-only mode |
| scl_in | input | 1 | Asynchronous two-wire clock; idles high |
| mode_in | input | 1 | Asynchronous mode request pin; reads low when left open |
| load_valid | input | 1 | Memory write beat is valid |
| load_ready | output | 1 | Memory write accepted (always 1) |
| load_addr | input | 7 | Memory write address |
| load_data | input | 8 | Memory write data |
| sda_oe | output | 1 | Open-drain pull-down enable; 1 pulls the line low |
| sda_out | output | 1 | Current bit value; 1 while released |
| tx_only | output | 1 | 1 in transmit-only mode, 0 in two-wire mode |

## Verification
A wrong lead counter or bit index shows on the line within one byte as a shifted bit pattern: a 0 arriving a pulse early or late, or a spacer bit in the wrong slot. A wrong address register shows as a wrong byte, starting at the first byte after entry or at the wrap from 127 to 0. A faulty mode counter shows as tx_only rising too early, too late or never, measured against the high and low run lengths on MODE. Because the reference model follows the block clock by clock, any of these faults is reported in the system clock cycle where the ports first differ.

// File: rtl/ddcid_pkg.sv
package ddcid_pkg;

  typedef enum logic [1:0] {
    SYNC_LEVEL = 2'd0,
    SYNC_RISE  = 2'd1,
    SYNC_FALL  = 2'd2
  } sync_kind_e;

  typedef enum logic [1:0] {
    MR_IDLE = 2'd0,
    MR_HIGH = 2'd1,
    MR_LOW  = 2'd2
  } mode_req_e;

endpackage

// File: rtl/ddcid_sync.sv
module ddcid_sync #(
  parameter ddcid_pkg::sync_kind_e KIND = ddcid_pkg::SYNC_LEVEL,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sig
);

  generate
    if (KIND == ddcid_pkg::SYNC_LEVEL) begin : g_level
      logic [1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= {2{RST_VAL}};
        else        stage <= {stage[0], din};
      end
      assign sig = stage[1];
    end else begin : g_edge
      logic [2:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= {3{RST_VAL}};
        else        stage <= {stage[1:0], din};
      end
      if (KIND == ddcid_pkg::SYNC_RISE) begin : g_rise
        assign sig = stage[1] & ~stage[2];
      end else begin : g_fall
        assign sig = ~stage[1] & stage[2];
      end
    end
  endgenerate

endmodule

// File: rtl/ddcid_mode_ctrl.sv
module ddcid_mode_ctrl #(
  parameter int MIN_PULSE = 250,
  localparam int CNT_W = $clog2(MIN_PULSE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  input  logic mode_lvl,
  output logic tx_only
);
  import ddcid_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_PULSE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  mode_req_e        req_st;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_only <= 1'b1;
      req_st  <= MR_IDLE;
      run_cnt <= '0;
    end else if (tx_only) begin
      req_st  <= MR_IDLE;
      run_cnt <= '0;
      if (scl_fall) tx_only <= 1'b0;
    end else begin
      unique case (req_st)
        MR_IDLE: begin
          if (mode_lvl) begin
            req_st  <= MR_HIGH;
            run_cnt <= CNT_ONE;
          end
        end
        MR_HIGH: begin
          if (mode_lvl) begin
            if (run_cnt != CNT_MAX) run_cnt <= run_cnt + CNT_ONE;
          end else if (run_cnt == CNT_MAX) begin
            req_st  <= MR_LOW;
            run_cnt <= CNT_ONE;
          end else begin
            req_st  <= MR_IDLE;
            run_cnt <= '0;
          end
        end
        MR_LOW: begin
          if (mode_lvl) begin
            req_st  <= MR_HIGH;
            run_cnt <= CNT_ONE;
          end else if (run_cnt == CNT_LAST) begin
            tx_only <= 1'b1;
            req_st  <= MR_IDLE;
            run_cnt <= '0;
          end else begin
            run_cnt <= run_cnt + CNT_ONE;
          end
        end
        default: begin
          req_st  <= MR_IDLE;
          run_cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ddcid_store.sv
module ddcid_store #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/ddcid_serializer.sv
module ddcid_serializer #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  parameter int LEAD_PULSES = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEAD_W = $clog2(LEAD_PULSES + 1),
  localparam int IDX_W  = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              vclk_rise,
  input  logic [WIDTH-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              bit_val,
  output logic              pull_low
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [LEAD_W-1:0] LEAD_END = LEAD_W'(LEAD_PULSES);
  localparam logic [IDX_W-1:0]  SPACER   = IDX_W'(WIDTH);

  logic [LEAD_W-1:0] lead_cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [WIDTH-1:0]  aligned;
  logic              next_bit;

  assign aligned  = rd_data << bit_idx;
  assign next_bit = aligned[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cnt <= '0;
      bit_idx  <= '0;
      rd_addr  <= TOP_ADDR;
      bit_val  <= 1'b1;
      pull_low <= 1'b0;
    end else if (!active) begin
      lead_cnt <= '0;
      bit_idx  <= '0;
      rd_addr  <= TOP_ADDR;
      bit_val  <= 1'b1;
      pull_low <= 1'b0;
    end else if (vclk_rise) begin
      if (lead_cnt != LEAD_END) begin
        lead_cnt <= lead_cnt + LEAD_W'(1);
        bit_val  <= 1'b1;
        pull_low <= 1'b0;
      end else if (bit_idx == SPACER) begin
        bit_idx  <= '0;
        bit_val  <= 1'b1;
        pull_low <= 1'b0;
        rd_addr  <= (rd_addr == TOP_ADDR) ? '0 : rd_addr + ADDR_W'(1);
      end else begin
        bit_idx  <= bit_idx + IDX_W'(1);
        bit_val  <= next_bit;
        pull_low <= ~next_bit;
      end
    end
  end

endmodule

// File: rtl/ddc_id_streamer.sv
module ddc_id_streamer #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  parameter int LEAD_PULSES = 9,
  parameter int MIN_PULSE = 250,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_in,
  input  logic              scl_in,
  input  logic              mode_in,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WIDTH-1:0]  load_data,
  output logic              sda_oe,
  output logic              sda_out,
  output logic              tx_only
);
  import ddcid_pkg::*;

  logic              vclk_rise;
  logic              scl_fall;
  logic              mode_lvl;
  logic [ADDR_W-1:0] rd_addr;
  logic [WIDTH-1:0]  rd_data;
  logic              bit_val;
  logic              pull_low;

  ddcid_sync #(.KIND(SYNC_RISE), .RST_VAL(1'b0)) u_vclk_sync (
    .clk(clk), .rst_n(rst_n), .din(vclk_in), .sig(vclk_rise)
  );

  ddcid_sync #(.KIND(SYNC_FALL), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_in), .sig(scl_fall)
  );

  ddcid_sync #(.KIND(SYNC_LEVEL), .RST_VAL(1'b0)) u_mode_sync (
    .clk(clk), .rst_n(rst_n), .din(mode_in), .sig(mode_lvl)
  );

  ddcid_mode_ctrl #(.MIN_PULSE(MIN_PULSE)) u_mode (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .mode_lvl(mode_lvl),
    .tx_only(tx_only)
  );

  ddcid_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .wr_en(load_valid), .wr_addr(load_addr), .wr_data(load_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  ddcid_serializer #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LEAD_PULSES(LEAD_PULSES)) u_ser (
    .clk(clk), .rst_n(rst_n), .active(tx_only), .vclk_rise(vclk_rise),
    .rd_data(rd_data), .rd_addr(rd_addr), .bit_val(bit_val), .pull_low(pull_low)
  );

  assign load_ready = 1'b1;
  assign sda_oe     = tx_only & pull_low;
  assign sda_out    = tx_only ? bit_val : 1'b1;

endmodule

// File: rtl/ddc_id_streamer_chk.sv
module ddc_id_streamer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_only,
  input logic sda_oe,
  input logic sda_out,
  input logic scl_fall,
  input logic mode_lvl,
  input logic vclk_rise
);

  // R6
  oe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !sda_out);

  // R6
  oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> tx_only);

  // R7
  scl_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_only && scl_fall) |=> !tx_only);

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_only && !scl_fall) |=> tx_only);

  // R9
  mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_only) |-> !$past(mode_lvl));

  // R10
  rearm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_only) |=> !sda_oe);

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_only && !vclk_rise) |=> ($stable(sda_out) || !tx_only));

endmodule

bind ddc_id_streamer ddc_id_streamer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_only(tx_only), .sda_oe(sda_oe),
  .sda_out(sda_out), .scl_fall(scl_fall), .mode_lvl(mode_lvl),
  .vclk_rise(vclk_rise)
);

// File: tb/ddc_id_streamer_test.sv
module ddc_id_streamer_test;

  localparam int MIN = 250;
  localparam int TOP = 127;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk = 1'b0;
  logic       scl = 1'b1;
  logic       mode = 1'b0;
  logic       load_valid = 1'b0;
  logic [6:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic       load_ready, sda_oe, sda_out, tx_only;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  ddc_id_streamer #(.MIN_PULSE(MIN)) uut (
    .clk(clk), .rst_n(rst_n), .vclk_in(vclk), .scl_in(scl), .mode_in(mode),
    .load_valid(load_valid), .load_ready(load_ready), .load_addr(load_addr),
    .load_data(load_data), .sda_oe(sda_oe), .sda_out(sda_out), .tx_only(tx_only)
  );

  // behavioural reference model
  bit hv[$] = '{1'b0, 1'b0, 1'b0, 1'b0};
  bit hs[$] = '{1'b1, 1'b1, 1'b1, 1'b1};
  bit hm[$] = '{1'b0, 1'b0, 1'b0, 1'b0};
  logic [7:0] m_mem [128];
  bit m_tx = 1, m_bit = 1, m_drv = 0;
  int m_pre = 0, m_idx = 0, m_addr = TOP;
  bit was_hi = 0, qual = 0;
  int hi = 0, lo = 0;

  always @(posedge clk) begin
    bit v_rise, s_fall, lvl, tx_old;
    hv.push_back(rst_n ? vclk : 1'b0);
    hs.push_back(rst_n ? scl : 1'b1);
    hm.push_back(rst_n ? mode : 1'b0);
    while (hv.size() > 4) void'(hv.pop_front());
    while (hs.size() > 4) void'(hs.pop_front());
    while (hm.size() > 4) void'(hm.pop_front());
    if (!rst_n) begin
      m_tx = 1; m_pre = 0; m_idx = 0; m_addr = TOP; m_bit = 1; m_drv = 0;
      was_hi = 0; hi = 0; lo = 0; qual = 0;
    end else begin
      v_rise = hv[1] && !hv[0];
      s_fall = !hs[1] && hs[0];
      lvl = hm[1];
      tx_old = m_tx;
      if (!tx_old) begin
        m_pre = 0; m_idx = 0; m_addr = TOP; m_bit = 1; m_drv = 0;
      end else if (v_rise) begin
        if (m_pre < 9) begin
          m_pre++; m_bit = 1; m_drv = 0;
        end else if (m_idx == 8) begin
          m_idx = 0; m_bit = 1; m_drv = 0; m_addr = (m_addr + 1) % 128;
        end else begin
          m_bit = m_mem[m_addr][7 - m_idx]; m_drv = !m_bit; m_idx++;
        end
      end
      if (tx_old) begin
        was_hi = 0; hi = 0; lo = 0; qual = 0;
        if (s_fall) m_tx = 0;
      end else if (lvl) begin
        if (!was_hi) hi = 0;
        if (hi < MIN) hi++;
        was_hi = 1; qual = 0; lo = 0;
      end else begin
        if (was_hi) begin qual = (hi >= MIN); lo = 0; end
        was_hi = 0; hi = 0;
        if (qual) begin
          lo++;
          if (lo >= MIN) begin m_tx = 1; qual = 0; lo = 0; end
        end
      end
    end
    if (load_valid) m_mem[load_addr] = load_data;
  end

  always @(negedge clk) begin
    bit e_oe, e_out;
    if (rst_n) begin
      e_oe = m_tx && m_drv;
      e_out = m_tx ? m_bit : 1'b1;
      checks++;
      if (sda_oe !== e_oe || sda_out !== e_out || tx_only !== m_tx) begin
        fails++;
        $display("FAIL %s model: oe/out/tx=%b%b%b expected %b%b%b at %0t",
                 phase, sda_oe, sda_out, tx_only, e_oe, e_out, m_tx, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vpulse(output bit line);
    vclk = 1'b1;
    wait_clk(6);
    line = sda_oe ? 1'b0 : 1'b1;
    vclk = 1'b0;
    wait_clk(6);
  endtask

  task automatic load(input int a, input int d);
    load_valid = 1'b1;
    load_addr = 7'(a);
    load_data = 8'(d);
    check("R11 ready", int'(load_ready), 1);
    wait_clk(1);
    load_valid = 1'b0;
  endtask

  function automatic int pattern(input int a);
    return ((a * 37) ^ (a >> 2) ^ 8'h5A) & 8'hFF;
  endfunction

  logic [7:0] shadow [128];

  task automatic expect_word(input string req, input int a);
    bit line;
    for (int b = 7; b >= 0; b--) begin
      vpulse(line);
      check(req, int'(line), int'(shadow[a][b]));
    end
    vpulse(line);
    check("R4 spacer", int'(line), 1);
  endtask

  task automatic expect_lead(input string req);
    bit line;
    for (int p = 0; p < 9; p++) begin
      vpulse(line);
      check(req, int'(line), 1);
    end
  endtask

  task automatic mode_pulse(input int hi_n, input int lo_n);
    mode = 1'b1;
    wait_clk(hi_n);
    mode = 1'b0;
    wait_clk(lo_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    bit line;
    wait_clk(3);
    check("R1 tx_only in reset", int'(tx_only), 1);
    check("R1 sda_oe in reset", int'(sda_oe), 0);
    check("R1 sda_out in reset", int'(sda_out), 1);
    rst_n = 1'b1;
    wait_clk(4);
    check("R1 tx_only after reset", int'(tx_only), 1);
    check("R1 sda_oe after reset", int'(sda_oe), 0);

    phase = "R11";
    for (int a = 0; a < 128; a++) begin
      shadow[a] = 8'(pattern(a));
      load(a, pattern(a));
    end
    shadow[127] = 8'h00;
    load(127, 8'h00);
    shadow[0] = 8'hFF;
    load(0, 8'hFF);

    phase = "R2/R3/R5";
    expect_lead("R2 lead release");
    expect_word("R5 first word top address", TOP);
    expect_word("R3 word 0", 0);
    phase = "R11";
    shadow[5] = 8'h3C;
    load(5, 8'h3C);
    phase = "R3/R5";
    for (int a = 1; a < 128; a++) expect_word("R5 ascending", a);
    expect_word("R5 wrap to 0", 0);
    expect_word("R5 after wrap", 1);

    phase = "R7";
    vpulse(line);
    vpulse(line);
    scl = 1'b0;
    wait_clk(6);
    check("R7 tx_only after scl fall", int'(tx_only), 0);
    check("R7 line released", int'(sda_oe), 0);
    scl = 1'b1;
    wait_clk(6);

    phase = "R8";
    for (int p = 0; p < 20; p++) begin
      vpulse(line);
      check("R8 vclk ignored", int'(line), 1);
    end
    scl = 1'b0; wait_clk(6); scl = 1'b1; wait_clk(6);
    check("R8 scl ignored", int'(tx_only), 0);

    phase = "R9";
    mode_pulse(100, MIN + 50);
    check("R9 short high", int'(tx_only), 0);
    mode_pulse(MIN + 50, 100);
    mode_pulse(50, MIN + 50);
    check("R9 short low", int'(tx_only), 0);
    mode_pulse(MIN + 50, MIN + 50);
    check("R9 valid pulse", int'(tx_only), 1);

    phase = "R10";
    expect_lead("R10 lead re-armed");
    expect_word("R10 restart at top", TOP);
    expect_word("R10 then 0", 0);

    phase = "R12";
    mode_pulse(MIN + 50, MIN + 50);
    check("R12 mode ignored", int'(tx_only), 1);
    expect_word("R12 stream continues", 1);
    expect_word("R12 stream continues", 2);

    summary();
    $finish;
  end

endmodule